// File: doc/BRIEF.md
# Configurable Serial Transmitter with Switchable Queue

This block turns bytes handed over by a host into asynchronous serial frames on a single output line. Each frame opens with a low start bit, carries 5 to 8 data bits least significant first, and closes with one or two high stop bits. The line rests high between frames. Every bit lasts from the moment it is driven until the next pulse on the bit strobe, which an external baud generator supplies.

Bytes wait in a buffer whose depth is chosen at run time: a 16-entry queue, or a single holding slot. The buffer reports when it is full, and a level flag tells the host when the queue has drained to a programmable depth or lower. Writes that find no room are discarded and leave a sticky overflow mark. A frame begins only while both the global enable and the transmit enable are high; word length and stop count are captured at the start of each frame.

Top module: `uart_txq`

## Requirements
- R1: The line idles at 1. A frame drives a 0 start bit, then the data bits least significant first, then 1 for each stop bit; the line changes only on a bit strobe or when a frame is loaded.
- R2: The word-length code `ctl_wlen` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits; only that many low bits of the byte are sent.
- R3: With `ctl_two_stop` at 1 a frame carries two stop bits, otherwise one; `busy` stays 1 through the last stop bit and is 0 in the cycle after the strobe that ends it.
- R4: With `ctl_q_en` at 1 the buffer holds up to 16 bytes; `full` rises on the 16th, and the bytes are sent one frame at a time in write order.
- R5: With `ctl_q_en` at 0 the buffer holds one byte, and `full` is 1 while that byte waits.
- R6: Only bits 7:0 of `wr_data` are used; the upper bits have no effect on the line.
- R7: A frame starts only when `ctl_on` and `ctl_tx_on` are both 1; with either at 0, queued bytes stay queued and the line stays high.
- R8: `below_thresh` is 1 exactly when the number of waiting bytes is less than or equal to `ctl_thresh` (0 to 15).
- R9: A write while the buffer is full and no byte leaves it in that cycle is dropped and sets `overflow`, which stays 1 until reset.
- R10: A write in the same cycle that the waiting byte moves into the shifter is accepted, even though `full` reads 1 in that cycle.
- R11: After reset `txd` is 1, `busy`, `full` and `overflow` are 0, and `below_thresh` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 32 | Write data; bits 7:0 carry the byte |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| ctl_on | input | 1 | Global enable |
| ctl_tx_on | input | 1 | Transmit enable |
| ctl_wlen | input | 2 | Word-length code (00=5 … 11=8 bits) |
| ctl_two_stop | input | 1 | 1 selects two stop bits |
| ctl_q_en | input | 1 | 1 selects the 16-deep queue, 0 the single slot |
| ctl_thresh | input | 4 | Level threshold for `below_thresh` |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is on the line |
| full | output | 1 | Buffer holds its capacity |
| below_thresh | output | 1 | Waiting bytes ≤ `ctl_thresh` |
| overflow | output | 1 | Sticky dropped-write mark |

## Verification
The write path and the hand-off from buffer to shifter can land in one cycle: in single-slot mode with transmission enabled, a byte is written and a second byte follows in the very next cycle, exactly when the first moves into the shifter. The second write must be kept and `overflow` must stay 0, while a third write one cycle later, with the slot occupied again and the shifter busy, must be dropped and raise `overflow`. The bench judges this from the decoded frames on `txd` (both bytes appear, in order, the third never does) and from `overflow` sampled after each write.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } tx_state_e;

  // Index of the last data bit for a word-length code: 00 -> 4 ... 11 -> 7.
  function automatic logic [2:0] last_index(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // Ring pointer advance with explicit wrap at an arbitrary depth.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/txq_buffer.sv
module txq_buffer #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_en,
  input  logic              push_req,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic              pop,
  output logic [BYTE_W-1:0] head_byte,
  output logic [LVL_W-1:0]  level,
  output logic              avail,
  output logic              full,
  output logic              accept,
  output logic              drop
);
  import uart_txq_pkg::*;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  cap;

  assign cap       = deep_en ? LVL_W'(DEPTH) : LVL_W'(1);
  assign full      = (level >= cap);
  assign avail     = (level != '0);
  assign accept    = push_req && (!full || pop);
  assign drop      = push_req && !accept;
  assign head_byte = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accept) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)    rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      level <= level + LVL_W'(accept) - LVL_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_byte;
  end

endmodule

// File: rtl/txq_serializer.sv
module txq_serializer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ok,
  input  logic              avail,
  input  logic [BYTE_W-1:0] head_byte,
  input  logic [1:0]        wlen_code,
  input  logic              two_stop,
  input  logic              bit_tick,
  output logic              take,
  output logic              txd,
  output logic              busy
);
  import uart_txq_pkg::*;

  tx_state_e         state;
  logic [BYTE_W-1:0] shreg;
  logic [2:0]        bit_idx, last_idx;
  logic              two_q, stop_idx, txd_q;

  assign take = (state == ST_IDLE) && go_ok && avail;
  assign busy = (state != ST_IDLE);
  assign txd  = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      txd_q    <= 1'b1;
      shreg    <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      two_q    <= 1'b0;
      stop_idx <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state    <= ST_START;
          txd_q    <= 1'b0;
          shreg    <= head_byte;
          last_idx <= last_index(wlen_code);
          two_q    <= two_stop;
        end
        ST_START: if (bit_tick) begin
          state   <= ST_DATA;
          txd_q   <= shreg[0];
          shreg   <= shreg >> 1;
          bit_idx <= '0;
        end
        ST_DATA: if (bit_tick) begin
          if (bit_idx == last_idx) begin
            state    <= ST_STOP;
            txd_q    <= 1'b1;
            stop_idx <= 1'b0;
          end else begin
            txd_q   <= shreg[0];
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 3'd1;
          end
        end
        ST_STOP: if (bit_tick) begin
          if (stop_idx == two_q) state <= ST_IDLE;
          else                   stop_idx <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH = 16,
  parameter int WR_W  = 32,
  localparam int BYTE_W = 8,
  localparam int THR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             wr_en,
  input  logic             ctl_on,
  input  logic             ctl_tx_on,
  input  logic [1:0]       ctl_wlen,
  input  logic             ctl_two_stop,
  input  logic             ctl_q_en,
  input  logic [THR_W-1:0] ctl_thresh,
  input  logic             bit_tick,
  output logic             txd,
  output logic             busy,
  output logic             full,
  output logic             below_thresh,
  output logic             overflow
);

  logic [BYTE_W-1:0] head_w;
  logic [LVL_W-1:0]  level_w;
  logic              avail_w, take_w, accept_w, drop_w, go_w;

  assign go_w = ctl_on && ctl_tx_on;

  txq_buffer #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .deep_en   (ctl_q_en),
    .push_req  (wr_en),
    .push_byte (wr_data[BYTE_W-1:0]),
    .pop       (take_w),
    .head_byte (head_w),
    .level     (level_w),
    .avail     (avail_w),
    .full      (full),
    .accept    (accept_w),
    .drop      (drop_w)
  );

  txq_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_ok     (go_w),
    .avail     (avail_w),
    .head_byte (head_w),
    .wlen_code (ctl_wlen),
    .two_stop  (ctl_two_stop),
    .bit_tick  (bit_tick),
    .take      (take_w),
    .txd       (txd),
    .busy      (busy)
  );

  assign below_thresh = (level_w <= LVL_W'(ctl_thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (drop_w) overflow <= 1'b1;
  end

endmodule

// File: rtl/uart_txq_checker.sv
module uart_txq_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_on,
  input logic             ctl_tx_on,
  input logic             ctl_q_en,
  input logic             wr_en,
  input logic             bit_tick,
  input logic             txd,
  input logic             busy,
  input logic             full,
  input logic             overflow,
  input logic             take,
  input logic             drop,
  input logic [LVL_W-1:0] level
);

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(txd));

  p_depth_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_single_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q_en && level != '0) |-> full);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_on && ctl_tx_on) |-> !take);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_pop_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_en) |-> !drop);

endmodule

bind uart_txq uart_txq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_on    (ctl_on),
  .ctl_tx_on (ctl_tx_on),
  .ctl_q_en  (ctl_q_en),
  .wr_en     (wr_en),
  .bit_tick  (bit_tick),
  .txd       (txd),
  .busy      (busy),
  .full      (full),
  .overflow  (overflow),
  .take      (take_w),
  .drop      (drop_w),
  .level     (level_w)
);

// File: tb/uart_txq_tb.sv
module uart_txq_tb;

  localparam int TICK_DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic        ctl_on = 1'b0, ctl_tx_on = 1'b0;
  logic [1:0]  ctl_wlen = 2'b00;
  logic        ctl_two_stop = 1'b0, ctl_q_en = 1'b0;
  logic [3:0]  ctl_thresh = 4'd0;
  logic        bit_tick = 1'b0;
  logic        txd, busy, full, below_thresh, overflow;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  uart_txq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
    .ctl_on(ctl_on), .ctl_tx_on(ctl_tx_on), .ctl_wlen(ctl_wlen),
    .ctl_two_stop(ctl_two_stop), .ctl_q_en(ctl_q_en), .ctl_thresh(ctl_thresh),
    .bit_tick(bit_tick), .txd(txd), .busy(busy), .full(full),
    .below_thresh(below_thresh), .overflow(overflow)
  );

  function automatic int bits_of(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  function automatic logic [7:0] sent_part(input logic [7:0] b, input logic [1:0] code);
    return b & 8'((1 << bits_of(code)) - 1);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit strobe: every TICK_DIV cycles, driven after the rising edge
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
      bit_tick = (cnt == 0);
    end
  end

  // line decoder, sampled at the falling edge
  int   d_state = 0, d_idx = 0, d_stops = 0;
  logic [7:0] d_data = '0;
  logic pend = 1'b0, pend_val = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(busy == pend_val, "R3 busy around stop bits", int'(busy), int'(pend_val));
        pend = 1'b0;
      end
      if (bit_tick) begin
        case (d_state)
          0: if (txd == 1'b0) begin d_state = 1; d_idx = 0; d_data = '0; end
          1: begin
            d_data[d_idx] = txd;
            d_idx++;
            if (d_idx == bits_of(ctl_wlen)) begin d_state = 2; d_stops = 0; end
          end
          default: begin
            chk(txd == 1'b1, "R1 stop bit level", int'(txd), 1);
            d_stops++;
            pend = 1'b1;
            if (d_stops == (ctl_two_stop ? 2 : 1)) begin
              pend_val = 1'b0;
              d_state = 0;
              if (exp_q.size() == 0) chk(1'b0, "R4 unexpected frame", int'(d_data), 0);
              else begin
                logic [7:0] e;
                e = sent_part(exp_q.pop_front(), ctl_wlen);
                chk(d_data == e, "R2 frame data", int'(d_data), int'(e));
              end
            end else pend_val = 1'b1;
          end
        endcase
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; wr_en = 1'b0; ctl_on = 1'b0; ctl_tx_on = 1'b0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic put(input logic [31:0] d, input logic keep);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    if (keep) exp_q.push_back(d[7:0]);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    @(posedge clk); #1;
    ctl_on = 1'b1; ctl_tx_on = 1'b1;
    while ((exp_q.size() != 0 || busy) && n < 4000) begin
      @(posedge clk); #1; n++;
    end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    ctl_on = 1'b0; ctl_tx_on = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    @(posedge clk); #1;
    // R11 reset state
    chk(txd == 1'b1, "R11 txd", int'(txd), 1);
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(full == 1'b0, "R11 full", int'(full), 0);
    chk(overflow == 1'b0, "R11 overflow", int'(overflow), 0);
    chk(below_thresh == 1'b1, "R11 below_thresh", int'(below_thresh), 1);

    // R5 single slot, R9 drop and sticky
    ctl_q_en = 1'b0; ctl_wlen = 2'b11; ctl_two_stop = 1'b0;
    put(32'h0000_00A5, 1'b1);
    chk(full == 1'b1, "R5 full after one byte", int'(full), 1);
    chk(overflow == 1'b0, "R9 no overflow yet", int'(overflow), 0);
    put(32'h0000_003C, 1'b0);
    chk(overflow == 1'b1, "R9 overflow on dropped write", int'(overflow), 1);
    drain("R5 single slot frame");
    chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);
    chk(full == 1'b0, "R5 empty after send", int'(full), 0);

    // R4 deep queue, R8 threshold, R6 upper bits
    do_reset();
    ctl_q_en = 1'b1; ctl_thresh = 4'd5; ctl_wlen = 2'b10; ctl_two_stop = 1'b1;
    for (int k = 1; k <= 17; k++) begin
      logic [31:0] d;
      d = $urandom();
      put(d, k <= 16);
      chk(full == (k >= 16), "R4 full at depth", int'(full), int'(k >= 16));
      chk(below_thresh == (k <= 5), "R8 level vs threshold", int'(below_thresh), int'(k <= 5));
      chk(overflow == (k == 17), "R9 overflow at 17th", int'(overflow), int'(k == 17));
    end
    drain("R4 sixteen frames in order R6");

    // R7 enables
    do_reset();
    ctl_q_en = 1'b1; ctl_wlen = 2'b01; ctl_two_stop = 1'b0;
    put(32'hFFFF_FF5A, 1'b1);
    put(32'h1234_56C3, 1'b1);
    ctl_on = 1'b0; ctl_tx_on = 1'b1;
    repeat (30) @(posedge clk); #1;
    chk(busy == 1'b0 && txd == 1'b1, "R7 held with global enable off", int'(busy), 0);
    ctl_on = 1'b1; ctl_tx_on = 1'b0;
    repeat (30) @(posedge clk); #1;
    chk(busy == 1'b0 && txd == 1'b1, "R7 held with transmit enable off", int'(busy), 0);
    ctl_on = 1'b0;
    drain("R7 frames after enabling");

    // R10 write while the slot is handed to the shifter
    do_reset();
    ctl_q_en = 1'b0; ctl_wlen = 2'b11; ctl_two_stop = 1'b0;
    ctl_on = 1'b1; ctl_tx_on = 1'b1;
    exp_q.push_back(8'h81); exp_q.push_back(8'h7E);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = 32'h81;
    @(posedge clk); #1; wr_data = 32'h7E;
    @(posedge clk); #1;
    chk(overflow == 1'b0, "R10 write during hand-off kept", int'(overflow), 0);
    wr_data = 32'h99;
    @(posedge clk); #1; wr_en = 1'b0;
    chk(overflow == 1'b1, "R9 third write dropped", int'(overflow), 1);
    drain("R10 both frames sent");

    // random batches: R1 R2 R3 R4 R8
    for (int b = 0; b < 12; b++) begin
      int n;
      do_reset();
      ctl_q_en = 1'b1;
      ctl_wlen = 2'($urandom_range(0, 3));
      ctl_two_stop = 1'($urandom_range(0, 1));
      ctl_thresh = 4'($urandom_range(0, 15));
      n = $urandom_range(1, 16);
      for (int k = 1; k <= n; k++) put($urandom(), 1'b1);
      chk(below_thresh == (n <= int'(ctl_thresh)), "R8 random level", int'(below_thresh),
          int'(n <= int'(ctl_thresh)));
      drain("R2 random batch");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule